// File: doc/BRIEF.md
# SPI Controller Module-Level Interrupt and Test Unit

This block holds the controller-wide registers of a four-channel SPI master: a fixed identification word, a system configuration word, a constant ready indication, the interrupt status and enable words, a wakeup enable bit, a test word and a module control word. The channel engines sit outside it. After each transfer attempt a channel pulses its `xfer_done` strobe together with its current transmit-empty flag, receive-full flag, transfer mode and turbo setting. From these the block sets that channel's interrupt status bits. The block drives one level interrupt, which is high whenever an enabled status bit is set.

Software reaches the registers through a simple request port. A read returns data one cycle after the request. A write takes effect at the clock edge that samples it. Only full-word accesses act. A test mode is active when module control bit 3 and test word bit 11 are both set. Entering it through either of those two writes sets every implemented status bit. While the mode stays active, clearing by writing ones is blocked. A system configuration write with bit 1 set returns the whole block to its reset state and pulses `chan_srst` so that the channel engines reset as well.

A three-state mode machine tracks this: `MODE_NORMAL` (no test, clears allowed), `MODE_TEST` (test active, clears blocked) and `MODE_RESET` (a one-cycle state after a soft reset, during which `chan_srst` is high). The transitions are as follows. Any state goes to `MODE_RESET` on a soft-reset write. `MODE_NORMAL` goes to `MODE_TEST` when a write makes the test condition true. `MODE_TEST` goes to `MODE_NORMAL` when a write makes it false. `MODE_RESET` goes to `MODE_TEST` or `MODE_NORMAL` according to the test condition after that cycle's write.

Top module: `spi_irq_ctl`

## Requirements
- R1: After reset, reads return 0 for interrupt status, interrupt enable, wakeup, test word and system configuration, and 0x4 for module control. `rd_valid`, `irq` and `chan_srst` are low.
- R2: Offset 0x00 always reads 0x91 and offset 0x14 always reads 0x1. Writes to either offset change nothing.
- R3: Writes keep only the implemented bits: interrupt enable (0x1C) keeps mask 0x1777F, test word (0x24) keeps [11:0], module control (0x28) keeps [3:0], wakeup (0x20) keeps bit 0, and system configuration (0x10) keeps mask 0x31D.
- R4: On a `xfer_done[n]` pulse, status bit 4n is set if `tx_empty_flag[n]` is high and the two-bit mode `xfer_mode[2n+1:2n]` is not 01. Mode encoding: 00 full duplex, 01 receive only, 10 transmit only.
- R5: On a `xfer_done[n]` pulse, status bit 4n+2 is set if `rx_full_flag[n]` is high, the mode is not 10 and `turbo_on[n]` is low.
- R6: Channel flags have no effect on status while `xfer_done` is low.
- R7: A write to the interrupt status word (0x18) clears each bit written as 1 and leaves the other bits unchanged.
- R8: `irq` is high exactly when status AND enable is nonzero.
- R9: Test mode is active when module control bit 3 and test word bit 11 are both set. A write to 0x24 or 0x28 that leaves test mode active sets every status bit in mask 0x1777F. Either write order works.
- R10: While test mode is active, writes to the interrupt status word have no effect.
- R11: A write to 0x10 with bit 1 set restores every register to its R1 value, then stores the written value masked by 0x31D. `chan_srst` is high for exactly the next cycle.
- R12: Reads of unmapped offsets return 0 and writes to them change nothing. Accesses with `req_word` low are ignored and read as 0.
- R13: Each read request produces exactly one `rd_valid` cycle, in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | Access is a full 32-bit word |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| xfer_done | input | 4 | Per-channel transfer-attempt strobe |
| tx_empty_flag | input | 4 | Per-channel transmit-empty flag |
| rx_full_flag | input | 4 | Per-channel receive-full flag |
| xfer_mode | input | 8 | Two-bit transfer mode per channel |
| turbo_on | input | 4 | Per-channel turbo setting |
| irq | output | 1 | Level interrupt |
| chan_srst | output | 1 | One-cycle soft-reset pulse to the channels |

## Verification
The bench puts all four channels through one attempt that mixes the modes, turbo and flags. A wrong mode or turbo decode would show up as a stray or missing bit in the exact status pattern. Test mode is entered in both write orders. A design that watched only one of the two registers would miss the forced pattern. A clear is attempted while test mode is active; a design that ignored the block would lose the forced bits. The soft reset is issued while the block is in test mode with bits forced. A design that left any register untouched, stored bit 1, or held `chan_srst` for the wrong number of cycles would read back wrong values.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int NCH    = 4;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam int ST_W   = 17;

    localparam logic [ST_W-1:0] IRQ_KEEP    = 17'h1777F;
    localparam logic [DW-1:0]   SYSCFG_KEEP = 32'h0000_031D;
    localparam logic [DW-1:0]   REV_WORD    = 32'h0000_0091;
    localparam logic [DW-1:0]   READY_WORD  = 32'h0000_0001;
    localparam int              TEST_W      = 12;
    localparam int              MCTL_W      = 4;
    localparam logic [MCTL_W-1:0] MCTL_INIT = 4'h4;
    localparam int              TEST_GATE   = 11;
    localparam int              MCTL_GATE   = 3;
    localparam int              SRST_BIT    = 1;

    localparam logic [AW-1:0] OFS_REV    = 8'h00;
    localparam logic [AW-1:0] OFS_SYSCFG = 8'h10;
    localparam logic [AW-1:0] OFS_READY  = 8'h14;
    localparam logic [AW-1:0] OFS_IRQST  = 8'h18;
    localparam logic [AW-1:0] OFS_IRQEN  = 8'h1C;
    localparam logic [AW-1:0] OFS_WAKE   = 8'h20;
    localparam logic [AW-1:0] OFS_TEST   = 8'h24;
    localparam logic [AW-1:0] OFS_MCTL   = 8'h28;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_TEST   = 2'd1,
        MODE_RESET  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        XFER_DUPLEX = 2'd0,
        XFER_RXONLY = 2'd1,
        XFER_TXONLY = 2'd2,
        XFER_RSVD   = 2'd3
    } xfer_e;

endpackage

// File: rtl/spi_irq_regbank.sv
module spi_irq_regbank
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              srst,
    output logic              test_now,
    output logic              test_next,
    output logic              test_write,
    output logic [DW-1:0]     sysconf,
    output logic [ST_W-1:0]   irq_en,
    output logic              wake_en,
    output logic [TEST_W-1:0] test_reg,
    output logic [MCTL_W-1:0] mctl
);

    logic hit_cfg, hit_en, hit_wake, hit_test, hit_mctl;
    logic [TEST_W-1:0] test_nx;
    logic [MCTL_W-1:0] mctl_nx;

    always_comb begin
        hit_cfg  = wr_en && (wr_addr == OFS_SYSCFG);
        hit_en   = wr_en && (wr_addr == OFS_IRQEN);
        hit_wake = wr_en && (wr_addr == OFS_WAKE);
        hit_test = wr_en && (wr_addr == OFS_TEST);
        hit_mctl = wr_en && (wr_addr == OFS_MCTL);
        srst     = hit_cfg && wr_data[SRST_BIT];
        test_nx  = hit_test ? wr_data[TEST_W-1:0] : test_reg;
        mctl_nx  = hit_mctl ? wr_data[MCTL_W-1:0] : mctl;
        test_now   = mctl[MCTL_GATE] && test_reg[TEST_GATE];
        test_next  = mctl_nx[MCTL_GATE] && test_nx[TEST_GATE];
        test_write = hit_test || hit_mctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sysconf  <= '0;
            irq_en   <= '0;
            wake_en  <= 1'b0;
            test_reg <= '0;
            mctl     <= MCTL_INIT;
        end else if (srst) begin
            sysconf  <= wr_data & SYSCFG_KEEP;
            irq_en   <= '0;
            wake_en  <= 1'b0;
            test_reg <= '0;
            mctl     <= MCTL_INIT;
        end else begin
            if (hit_cfg)  sysconf  <= wr_data & SYSCFG_KEEP;
            if (hit_en)   irq_en   <= wr_data[ST_W-1:0] & IRQ_KEEP;
            if (hit_wake) wake_en  <= wr_data[0];
            test_reg <= test_nx;
            mctl     <= mctl_nx;
        end
    end

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (mctl == MCTL_INIT && test_reg == '0 && irq_en == '0 && !wake_en)); // R11

    AST_SYSCFG_BIT1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg |=> !sysconf[SRST_BIT]); // R11

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              force_all,
    input  logic              clr_req,
    input  logic [ST_W-1:0]   clr_bits,
    input  logic              clr_block,
    input  logic [NCH-1:0]    att,
    input  logic [NCH-1:0]    txs,
    input  logic [NCH-1:0]    rxs,
    input  logic [2*NCH-1:0]  mode,
    input  logic [NCH-1:0]    turbo,
    output logic [ST_W-1:0]   status
);

    logic [NCH-1:0]  tx_set;
    logic [NCH-1:0]  rx_set;
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] clr_mask;
    logic [ST_W-1:0] status_nx;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        xfer_e m;
        assign m = xfer_e'(mode[2*g +: 2]);
        assign tx_set[g] = att[g] && txs[g] && (m != XFER_RXONLY);
        assign rx_set[g] = att[g] && rxs[g] && (m != XFER_TXONLY) && !turbo[g];

        AST_TX_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (att[g] && txs[g] && mode[2*g +: 2] != 2'b01 && !srst) |=> status[4*g]); // R4

        AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (att[g] && rxs[g] && mode[2*g +: 2] != 2'b10 && !turbo[g] && !srst)
            |=> status[4*g+2]); // R5
    end

    always_comb begin
        set_vec = '0;
        for (int c = 0; c < NCH; c++) begin
            set_vec[4*c]   = tx_set[c];
            set_vec[4*c+2] = rx_set[c];
        end
        clr_mask  = (clr_req && !clr_block) ? clr_bits : '0;
        status_nx = ((status & ~clr_mask) | set_vec | (force_all ? IRQ_KEEP : '0)) & IRQ_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      status <= '0;
        else if (srst)   status <= '0;
        else             status <= status_nx;
    end

    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_block && !force_all && !srst && att == '0) |=> status == $past(status)); // R10

    AST_FORCE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (force_all && !srst) |=> status == IRQ_KEEP); // R9

    AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~IRQ_KEEP) == '0); // R9

endmodule

// File: rtl/spi_irq_mode_fsm.sv
module spi_irq_mode_fsm
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic test_next,
    input  logic test_now,
    output logic clr_block,
    output logic chan_srst
);

    mode_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MODE_NORMAL;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MODE_NORMAL: begin
                if (srst)           state_nx = MODE_RESET;
                else if (test_next) state_nx = MODE_TEST;
            end
            MODE_TEST: begin
                if (srst)            state_nx = MODE_RESET;
                else if (!test_next) state_nx = MODE_NORMAL;
            end
            MODE_RESET: begin
                if (srst)           state_nx = MODE_RESET;
                else if (test_next) state_nx = MODE_TEST;
                else                state_nx = MODE_NORMAL;
            end
            default: state_nx = MODE_NORMAL;
        endcase
    end

    always_comb begin
        clr_block = (state == MODE_TEST);
        chan_srst = (state == MODE_RESET);
    end

    AST_TEST_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MODE_TEST) == test_now); // R10

    AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_srst && !srst) |=> !chan_srst); // R11

endmodule

// File: rtl/spi_irq_ctl.sv
module spi_irq_ctl
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic [3:0]        xfer_done,
    input  logic [3:0]        tx_empty_flag,
    input  logic [3:0]        rx_full_flag,
    input  logic [7:0]        xfer_mode,
    input  logic [3:0]        turbo_on,
    output logic              irq,
    output logic              chan_srst
);

    logic              wr_en, rd_en;
    logic              srst, test_now, test_next, test_write;
    logic              clr_block, force_all, clr_req;
    logic [DW-1:0]     sysconf;
    logic [ST_W-1:0]   irq_en;
    logic              wake_en;
    logic [TEST_W-1:0] test_reg;
    logic [MCTL_W-1:0] mctl;
    logic [ST_W-1:0]   status;
    logic [DW-1:0]     rd_mux;

    assign wr_en     = req_valid && req_write && req_word;
    assign rd_en     = req_valid && !req_write;
    assign clr_req   = wr_en && (req_addr == OFS_IRQST);
    assign force_all = test_write && test_next;

    spi_irq_regbank u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (req_addr),
        .wr_data    (req_wdata),
        .srst       (srst),
        .test_now   (test_now),
        .test_next  (test_next),
        .test_write (test_write),
        .sysconf    (sysconf),
        .irq_en     (irq_en),
        .wake_en    (wake_en),
        .test_reg   (test_reg),
        .mctl       (mctl)
    );

    spi_irq_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .test_next (test_next),
        .test_now  (test_now),
        .clr_block (clr_block),
        .chan_srst (chan_srst)
    );

    spi_irq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst),
        .force_all (force_all),
        .clr_req   (clr_req),
        .clr_bits  (req_wdata[ST_W-1:0]),
        .clr_block (clr_block),
        .att       (xfer_done),
        .txs       (tx_empty_flag),
        .rxs       (rx_full_flag),
        .mode      (xfer_mode),
        .turbo     (turbo_on),
        .status    (status)
    );

    always_comb begin
        rd_mux = '0;
        if (req_word) begin
            unique case (req_addr)
                OFS_REV:    rd_mux = REV_WORD;
                OFS_SYSCFG: rd_mux = sysconf;
                OFS_READY:  rd_mux = READY_WORD;
                OFS_IRQST:  rd_mux = DW'(status);
                OFS_IRQEN:  rd_mux = DW'(irq_en);
                OFS_WAKE:   rd_mux = DW'(wake_en);
                OFS_TEST:   rd_mux = DW'(test_reg);
                OFS_MCTL:   rd_mux = DW'(mctl);
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    assign irq = |(status & irq_en);

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq); // R8

    AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid)); // R13

endmodule

// File: tb/sim_spi_irq_ctl.sv
`timescale 1ns/1ps
module sim_spi_irq_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  xfer_done = '0, tx_empty_flag = '0, rx_full_flag = '0, turbo_on = '0;
    logic [7:0]  xfer_mode = '0;
    logic        irq, chan_srst;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    spi_irq_ctl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .xfer_done(xfer_done),
        .tx_empty_flag(tx_empty_flag), .rx_full_flag(rx_full_flag),
        .xfer_mode(xfer_mode), .turbo_on(turbo_on), .irq(irq), .chan_srst(chan_srst)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit w, input bit word, input logic [7:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = w; req_word = word; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus(1'b0, 1'b1, a, '0);
    endtask

    task automatic pulse(input logic [3:0] t, input logic [3:0] r, input logic [7:0] m, input logic [3:0] tb);
        tx_empty_flag = t; rx_full_flag = r; xfer_mode = m; turbo_on = tb; xfer_done = 4'hF;
        @(negedge clk);
        xfer_done = 4'h0;
    endtask

    always @(negedge clk) begin : monitor
        logic [31:0] e;
        string t;
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R13 rd_valid without request", rd_data, 32'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rd_data === e, t, rd_data, e);
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R13 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && !irq && !chan_srst, "R1 reset outputs", {29'h0, rd_valid, irq, chan_srst}, 32'h0);
        rd(8'h00, 32'h91, "R2 revision");
        rd(8'h10, 32'h0, "R1 sysconfig");
        rd(8'h14, 32'h1, "R2 ready");
        rd(8'h18, 32'h0, "R1 status");
        rd(8'h1C, 32'h0, "R1 enable");
        rd(8'h20, 32'h0, "R1 wakeup");
        rd(8'h24, 32'h0, "R1 test word");
        rd(8'h28, 32'h4, "R1 module control");

        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h14, 32'h0);
        rd(8'h00, 32'h91, "R2 revision after write");
        rd(8'h14, 32'h1, "R2 ready after write");

        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h1777F, "R3 enable mask");
        wr(8'h1C, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, 32'hFFF, "R3 test mask");
        rd(8'h18, 32'h0, "R9 no force without control bit");
        wr(8'h24, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, 32'h1, "R3 wakeup mask");
        wr(8'h28, 32'hFFFF_FFF3); rd(8'h28, 32'h3, "R3 control mask");
        wr(8'h10, 32'hFFFF_FFFD); rd(8'h10, 32'h31D, "R3 sysconfig mask");

        tx_empty_flag = 4'hF; rx_full_flag = 4'hF;
        repeat (3) @(negedge clk);
        rd(8'h18, 32'h0, "R6 flags without strobe");

        pulse(4'hF, 4'h0, 8'h00, 4'h0);
        rd(8'h18, 32'h1111, "R4 all channels transmit empty");
        wr(8'h18, 32'h0000_0101);
        rd(8'h18, 32'h1010, "R7 write one to clear");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0, "R7 clear all");

        pulse(4'b0111, 4'b1111, {2'b00, 2'b00, 2'b10, 2'b01}, 4'b0100);
        rd(8'h18, 32'h4114, "R5 mode and turbo decode");

        wr(8'h1C, 32'h4); @(negedge clk);
        chk(irq === 1'b1, "R8 enabled bit raises irq", {31'h0, irq}, 32'h1);
        wr(8'h1C, 32'h1);
        chk(irq === 1'b0, "R8 disabled bit keeps irq low", {31'h0, irq}, 32'h0);
        wr(8'h1C, 32'h10000);
        chk(irq === 1'b0, "R8 no irq before force", {31'h0, irq}, 32'h0);

        wr(8'h24, 32'h800);
        rd(8'h18, 32'h4114, "R9 test bit alone does not force");
        wr(8'h28, 32'h8);
        chk(irq === 1'b1, "R9 forced bit 16 raises irq", {31'h0, irq}, 32'h1);
        rd(8'h18, 32'h1777F, "R9 force via control write");
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h1777F, "R10 clear blocked in test mode");
        wr(8'h28, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, 32'h0, "R10 clear works after test exit");
        wr(8'h24, 32'h0);
        wr(8'h28, 32'h8);
        rd(8'h18, 32'h0, "R9 control bit alone does not force");
        wr(8'h24, 32'h800);
        rd(8'h18, 32'h1777F, "R9 force via test word write");
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h1777F, "R10 single bit clear blocked");

        wr(8'h10, 32'h3);
        chk(chan_srst === 1'b1, "R11 channel reset pulse", {31'h0, chan_srst}, 32'h1);
        chk(irq === 1'b0, "R11 irq low after soft reset", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk(chan_srst === 1'b0, "R11 channel reset one cycle", {31'h0, chan_srst}, 32'h0);
        rd(8'h10, 32'h1, "R11 sysconfig stored masked");
        rd(8'h18, 32'h0, "R11 status cleared");
        rd(8'h1C, 32'h0, "R11 enable cleared");
        rd(8'h20, 32'h0, "R11 wakeup cleared");
        rd(8'h24, 32'h0, "R11 test word cleared");
        rd(8'h28, 32'h4, "R11 control restored");

        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C, 32'h0, "R12 unmapped read");
        rd(8'h04, 32'h0, "R12 unmapped gap");
        bus(1'b1, 1'b0, 8'h1C, 32'hFF);
        rd(8'h1C, 32'h0, "R12 partial write ignored");
        exp_q.push_back(32'h0); tag_q.push_back("R12 partial read is zero");
        bus(1'b0, 1'b0, 8'h00, 32'h0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R13 every read answered", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule